// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses through one fully associative array that serves both instruction fetches and data accesses. Every entry keeps its own page size, chosen from eight sizes that grow by a factor of four from 1KB up to 16MB, so large and small pages can sit side by side. A lookup presents a virtual address, an 8-bit process ID, an access kind and a privilege flag. In the same cycle it returns a hit or a protection fault, the physical address, the index of the matching entry and the entry's attribute bits.

Software owns the array. It loads or clears any entry through a write port, chooses which entry to overwrite, and programs a 16-slot zone table. An entry names one zone slot, and that slot's 2-bit code can narrow or widen the entry's own permissions. Instruction translation and data translation each have their own enable. When the enable for an access kind is off, the address passes through untranslated.

Top module: `tlb_xlate_top`

## Requirements
- R1: After reset every entry is invalid and every zone code is 01. A requested lookup with translation enabled then gives lk_hit=0 and lk_fault=0, and with no request both outputs are 0.
- R2: lk_kind encodes 00 read, 01 store, 10 fetch and 11 read. A fetch is governed by xl_inst_en and every other kind by xl_data_en. With the governing enable low, a requested lookup gives lk_hit=1, lk_fault=0, lk_paddr=lk_vaddr and lk_attr=0.
- R3: The 3-bit size field n gives a page of 1KB times 4 to the power n. A valid entry matches when lk_vaddr[31:10+2n] equals the same bits of the entry's page number ({vpn,10'b0}).
- R4: On a hit, lk_paddr takes bits 31:10+2n from the entry's frame number ({ppn,10'b0}) and bits 10+2n-1:0 from lk_vaddr.
- R5: A match also needs the entry's process ID to equal lk_pid, except that an entry whose process ID is 0 matches every lk_pid.
- R6: When several valid entries match, the lowest-numbered one decides the result, and lk_idx reports its index.
- R7: Under zone code 01 the entry's own permissions apply: a read is always allowed, a store needs the W bit and a fetch needs the X bit. A denied access gives lk_fault=1 and lk_hit=0.
- R8: Zone code 00 allows access only when lk_priv=1, and then the entry's permissions still apply. Zone code 10 allows reads and stores, while a fetch still needs X. Zone code 11 allows every kind.
- R9: A zone-table write (zw_en) sets the code of slot zw_idx. The code used for a lookup is the one in the slot named by the matching entry's zone field.
- R10: An entry write (ew_en) loads or, with ew_valid=0, clears the entry at ew_idx. A lookup in the same cycle as the write still sees the old contents, and lookups from the next cycle on see the new ones.
- R11: On a translated hit, lk_attr carries the entry's attribute bits. On a miss or a fault lk_attr is 0, and with lk_req=0 lk_hit and lk_fault stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Process ID of the access |
| lk_kind | input | 2 | Access kind (00 read, 01 store, 10 fetch, 11 read) |
| lk_priv | input | 1 | Access is privileged |
| xl_inst_en | input | 1 | Enables translation for fetches |
| xl_data_en | input | 1 | Enables translation for reads and stores |
| lk_hit | output | 1 | Translation succeeded |
| lk_fault | output | 1 | An entry matched but access is denied |
| lk_paddr | output | 32 | Physical address |
| lk_idx | output | 6 | Index of the matching entry |
| lk_attr | output | 2 | Attribute bits of the matching entry |
| ew_en | input | 1 | Entry write strobe |
| ew_idx | input | 6 | Entry to write |
| ew_valid | input | 1 | Valid bit to store (0 clears the entry) |
| ew_vpn | input | 22 | Virtual page number (address bits 31:10) |
| ew_size | input | 3 | Page size code n |
| ew_pid | input | 8 | Process ID of the entry (0 matches any) |
| ew_ppn | input | 22 | Physical frame number (address bits 31:10) |
| ew_w | input | 1 | Store permission |
| ew_x | input | 1 | Fetch permission |
| ew_attr | input | 2 | Attribute bits |
| ew_zone | input | 4 | Zone slot selected by the entry |
| zw_en | input | 1 | Zone-table write strobe |
| zw_idx | input | 4 | Zone slot to write |
| zw_code | input | 2 | Zone code to store |

## Verification
Addresses are placed at the first and last byte of a page and one byte past its end. This is done for the 1KB, 64KB, 1MB and 16MB sizes, so that a mask one size too wide or too narrow shows up as a wrong hit or a wrong frame bit. Two entries of different sizes are made to cover the same address, and the lower one is then cleared, which shows whether selection follows the index order rather than the size or the write order. Each access kind is tried under every zone code, with and without privilege, and with each enable off in turn. This separates the entry permissions from the zone overrides and the fetch path from the data path. One write coincides with a lookup to the same entry, which pins down the cycle in which the new contents become visible.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int SIZE_W = 3;
  localparam int PID_W  = 8;
  localparam int ATTR_W = 2;
  localparam int ZIDX_W = 4;
  localparam int ZONES  = 1 << ZIDX_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    ZN_PRIV  = 2'b00,
    ZN_ENTRY = 2'b01,
    ZN_RW    = 2'b10,
    ZN_ALL   = 2'b11
  } zone_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [SIZE_W-1:0] size;
    logic [PID_W-1:0]  pid;
    logic [VPN_W-1:0]  ppn;
    logic              w;
    logic              x;
    logic [ATTR_W-1:0] attr;
    logic [ZIDX_W-1:0] zone;
  } ent_t;

  // Page-number bits that take part in the compare for size code sz.
  function automatic logic [VPN_W-1:0] keep_mask(input logic [SIZE_W-1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    for (int b = 0; b < VPN_W; b++) begin
      if (b < 2 * int'(sz)) m[b] = 1'b0;
    end
    return m;
  endfunction

  // Frame bits above the page offset, virtual bits inside it.
  function automatic logic [VPN_W-1:0] splice(input logic [VPN_W-1:0] ppn,
                                              input logic [VPN_W-1:0] vpn,
                                              input logic [SIZE_W-1:0] sz);
    logic [VPN_W-1:0] m;
    m = keep_mask(sz);
    return (ppn & m) | (vpn & ~m);
  endfunction

  function automatic logic ent_allows(input acc_e acc, input logic w, input logic x);
    case (acc)
      ACC_STORE: return w;
      ACC_FETCH: return x;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic zone_allows(input zone_e code, input acc_e acc,
                                       input logic priv, input logic w, input logic x);
    case (code)
      ZN_PRIV:  return priv && ent_allows(acc, w, x);
      ZN_ENTRY: return ent_allows(acc, w, x);
      ZN_RW:    return (acc == ACC_FETCH) ? x : 1'b1;
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_xlate_pkg::*;
(
  input  ent_t             ent,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic             match
);
  logic tag_eq;
  logic pid_ok;

  assign tag_eq = (((ent.vpn ^ vpn) & keep_mask(ent.size)) == '0);
  assign pid_ok = (ent.pid == '0) || (ent.pid == pid);
  assign match  = ent.valid && tag_eq && pid_ok;
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ent_t             wr_ent,
  output ent_t             ents [ENTRIES]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
    end else if (wr_en) begin
      ents[wr_idx] <= wr_ent;
    end
  end
endmodule

// File: rtl/tlb_zone_regs.sv
module tlb_zone_regs
  import tlb_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ZIDX_W-1:0] wr_idx,
  input  logic [1:0]        wr_code,
  input  logic [ZIDX_W-1:0] rd_idx,
  output zone_e             rd_code
);
  zone_e codes [ZONES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ZONES; i++) codes[i] <= ZN_ENTRY;
    end else if (wr_en) begin
      codes[wr_idx] <= zone_e'(wr_code);
    end
  end

  assign rd_code = codes[rd_idx];
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_xlate_top.sv
module tlb_xlate_top
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [1:0]        lk_kind,
  input  logic              lk_priv,
  input  logic              xl_inst_en,
  input  logic              xl_data_en,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [VA_W-1:0]   lk_paddr,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              ew_en,
  input  logic [IDX_W-1:0]  ew_idx,
  input  logic              ew_valid,
  input  logic [VPN_W-1:0]  ew_vpn,
  input  logic [SIZE_W-1:0] ew_size,
  input  logic [PID_W-1:0]  ew_pid,
  input  logic [VPN_W-1:0]  ew_ppn,
  input  logic              ew_w,
  input  logic              ew_x,
  input  logic [ATTR_W-1:0] ew_attr,
  input  logic [ZIDX_W-1:0] ew_zone,
  input  logic              zw_en,
  input  logic [ZIDX_W-1:0] zw_idx,
  input  logic [1:0]        zw_code
);
  ent_t             wr_ent;
  ent_t             ents [ENTRIES];
  ent_t             sel_ent;
  logic [ENTRIES-1:0] match_vec;
  logic             any_match;
  logic [IDX_W-1:0] sel_idx;
  zone_e            zone_code;
  acc_e             acc;
  logic             is_fetch;
  logic             xlate_on;
  logic             perm_ok;
  logic [VPN_W-1:0] lk_vpn;

  always_comb begin
    wr_ent       = '0;
    wr_ent.valid = ew_valid;
    wr_ent.vpn   = ew_vpn;
    wr_ent.size  = ew_size;
    wr_ent.pid   = ew_pid;
    wr_ent.ppn   = ew_ppn;
    wr_ent.w     = ew_w;
    wr_ent.x     = ew_x;
    wr_ent.attr  = ew_attr;
    wr_ent.zone  = ew_zone;
  end

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ew_en),
    .wr_idx (ew_idx),
    .wr_ent (wr_ent),
    .ents   (ents)
  );

  assign lk_vpn = lk_vaddr[VA_W-1:PG_LSB];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_entry_cmp u_cmp (
      .ent   (ents[g]),
      .vpn   (lk_vpn),
      .pid   (lk_pid),
      .match (match_vec[g])
    );
  end

  tlb_first_hit #(.N(ENTRIES)) u_pick (
    .vec   (match_vec),
    .found (any_match),
    .idx   (sel_idx)
  );

  assign sel_ent = ents[sel_idx];

  tlb_zone_regs u_zones (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (zw_en),
    .wr_idx  (zw_idx),
    .wr_code (zw_code),
    .rd_idx  (sel_ent.zone),
    .rd_code (zone_code)
  );

  assign acc      = acc_e'(lk_kind);
  assign is_fetch = (acc == ACC_FETCH);
  assign xlate_on = is_fetch ? xl_inst_en : xl_data_en;
  assign perm_ok  = zone_allows(zone_code, acc, lk_priv, sel_ent.w, sel_ent.x);

  always_comb begin
    lk_hit   = 1'b0;
    lk_fault = 1'b0;
    lk_attr  = '0;
    lk_idx   = sel_idx;
    if (!xlate_on) lk_paddr = lk_vaddr;
    else lk_paddr = {splice(sel_ent.ppn, lk_vpn, sel_ent.size), lk_vaddr[PG_LSB-1:0]};
    if (lk_req) begin
      if (!xlate_on) begin
        lk_hit = 1'b1;
      end else if (any_match) begin
        lk_hit   = perm_ok;
        lk_fault = !perm_ok;
        if (perm_ok) lk_attr = sel_ent.attr;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_hit,
  input logic               lk_fault,
  input logic [VA_W-1:0]    lk_paddr,
  input logic [IDX_W-1:0]   lk_idx,
  input logic [ATTR_W-1:0]  lk_attr,
  input logic               ew_en,
  input logic               ew_valid,
  input logic [IDX_W-1:0]   ew_idx,
  input logic [ENTRIES-1:0] match_vec,
  input logic               any_match,
  input logic               xlate_on
);
  logic [ENTRIES-1:0] below;
  assign below = (ENTRIES'(1) << lk_idx) - ENTRIES'(1);

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> match_vec == '0);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !xlate_on) |-> (lk_hit && !lk_fault && lk_paddr == lk_vaddr && lk_attr == '0));

  assert_nomatch_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && xlate_on && !any_match) |-> (!lk_hit && !lk_fault));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[PG_LSB-1:0] == lk_vaddr[PG_LSB-1:0]);

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_hit || lk_fault) && xlate_on) |-> (match_vec[lk_idx] && (match_vec & below) == '0));

  assert_hit_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  assert_clear_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_en && !ew_valid) |=> !match_vec[$past(ew_idx)]);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !lk_fault));
endmodule

bind tlb_xlate_top tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .lk_vaddr  (lk_vaddr),
  .lk_hit    (lk_hit),
  .lk_fault  (lk_fault),
  .lk_paddr  (lk_paddr),
  .lk_idx    (lk_idx),
  .lk_attr   (lk_attr),
  .ew_en     (ew_en),
  .ew_valid  (ew_valid),
  .ew_idx    (ew_idx),
  .match_vec (match_vec),
  .any_match (any_match),
  .xlate_on  (xlate_on)
);

// File: tb/tb_tlb_xlate_top.sv
module tb_tlb_xlate_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        lk_req, lk_priv, xl_inst_en, xl_data_en;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_pid;
  logic [1:0]  lk_kind;
  logic        lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic [5:0]  lk_idx;
  logic [1:0]  lk_attr;
  logic        ew_en, ew_valid, ew_w, ew_x;
  logic [5:0]  ew_idx;
  logic [21:0] ew_vpn, ew_ppn;
  logic [2:0]  ew_size;
  logic [7:0]  ew_pid;
  logic [1:0]  ew_attr;
  logic [3:0]  ew_zone;
  logic        zw_en;
  logic [3:0]  zw_idx;
  logic [1:0]  zw_code;

  tlb_xlate_top dut (.*);

  typedef struct {
    bit hit; bit fault; bit [31:0] pa; int idx; bit [1:0] attr; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  // Reference state of the array, zone table and enables
  bit        mv[64];
  bit [21:0] mvpn[64], mppn[64];
  bit [2:0]  msz[64];
  bit [7:0]  mpid[64];
  bit        mw[64], mx[64];
  bit [1:0]  mattr[64];
  bit [3:0]  mzone[64];
  bit [1:0]  zcode[16];

  function automatic exp_t predict(bit [31:0] va, bit [7:0] pid, bit [1:0] kind, bit priv, string tag);
    exp_t e;
    int hitat;
    bit on, own, ok;
    int sh;
    bit [31:0] vbase, fbase;
    e.tag = tag; e.hit = 0; e.fault = 0; e.pa = 0; e.idx = -1; e.attr = 0;
    on = (kind == 2'b10) ? xl_inst_en : xl_data_en;
    if (!on) begin e.hit = 1; e.pa = va; return e; end
    hitat = -1;
    for (int i = 0; i < 64; i++) begin
      if (hitat < 0 && mv[i]) begin
        sh = 10 + 2 * int'(msz[i]);
        vbase = {mvpn[i], 10'b0};
        if ((va >> sh) == (vbase >> sh) && (mpid[i] == 0 || mpid[i] == pid)) hitat = i;
      end
    end
    if (hitat < 0) return e;
    own = (kind == 2'b01) ? mw[hitat] : (kind == 2'b10) ? mx[hitat] : 1'b1;
    case (zcode[mzone[hitat]])
      2'b00: ok = priv && own;
      2'b01: ok = own;
      2'b10: ok = (kind == 2'b10) ? mx[hitat] : 1'b1;
      default: ok = 1'b1;
    endcase
    e.idx = hitat;
    if (ok) begin
      sh = 10 + 2 * int'(msz[hitat]);
      fbase = {mppn[hitat], 10'b0};
      e.hit = 1;
      e.pa = ((fbase >> sh) << sh) | (va & ((32'h1 << sh) - 1));
      e.attr = mattr[hitat];
    end else begin
      e.fault = 1;
    end
    return e;
  endfunction

  // Monitor: compare each requested lookup against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && lk_req === 1'b1) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: lookup with nothing expected (hit=%0b)", lk_hit);
        end else begin
          e = q.pop_front();
          if (lk_hit !== e.hit || lk_fault !== e.fault ||
              (e.hit && lk_paddr !== e.pa) ||
              ((e.hit || e.fault) && e.idx >= 0 && int'(lk_idx) != e.idx) ||
              lk_attr !== e.attr) begin
            errors++;
            $display("FAIL %s: act hit=%0b fault=%0b pa=%h idx=%0d attr=%0d exp hit=%0b fault=%0b pa=%h idx=%0d attr=%0d",
                     e.tag, lk_hit, lk_fault, lk_paddr, lk_idx, lk_attr,
                     e.hit, e.fault, e.pa, e.idx, e.attr);
          end
        end
      end
    end
  end

  task automatic drive_look(bit [31:0] va, bit [7:0] pid, bit [1:0] kind, bit priv);
    lk_vaddr = va; lk_pid = pid; lk_kind = kind; lk_priv = priv; lk_req = 1'b1;
  endtask

  task automatic look(bit [31:0] va, bit [7:0] pid, bit [1:0] kind, bit priv, string tag);
    @(posedge clk); #1;
    ew_en = 1'b0; zw_en = 1'b0;
    drive_look(va, pid, kind, priv);
    q.push_back(predict(va, pid, kind, priv, tag));
  endtask

  task automatic drive_ent(int idx, bit v, bit [21:0] vpn, bit [2:0] sz, bit [7:0] pid,
                           bit [21:0] ppn, bit w, bit x, bit [1:0] attr, bit [3:0] zone);
    ew_en = 1'b1; ew_idx = 6'(idx); ew_valid = v; ew_vpn = vpn; ew_size = sz; ew_pid = pid;
    ew_ppn = ppn; ew_w = w; ew_x = x; ew_attr = attr; ew_zone = zone;
  endtask

  task automatic model_ent(int idx, bit v, bit [21:0] vpn, bit [2:0] sz, bit [7:0] pid,
                           bit [21:0] ppn, bit w, bit x, bit [1:0] attr, bit [3:0] zone);
    mv[idx] = v; mvpn[idx] = vpn; msz[idx] = sz; mpid[idx] = pid; mppn[idx] = ppn;
    mw[idx] = w; mx[idx] = x; mattr[idx] = attr; mzone[idx] = zone;
  endtask

  task automatic put_ent(int idx, bit v, bit [31:0] va, bit [2:0] sz, bit [7:0] pid,
                         bit [21:0] ppn, bit w, bit x, bit [1:0] attr, bit [3:0] zone);
    @(posedge clk); #1;
    lk_req = 1'b0;
    drive_ent(idx, v, va[31:10], sz, pid, ppn, w, x, attr, zone);
    @(posedge clk); #1;
    ew_en = 1'b0;
    model_ent(idx, v, va[31:10], sz, pid, ppn, w, x, attr, zone);
  endtask

  task automatic put_zone(int idx, bit [1:0] code);
    @(posedge clk); #1;
    lk_req = 1'b0;
    zw_en = 1'b1; zw_idx = 4'(idx); zw_code = code;
    @(posedge clk); #1;
    zw_en = 1'b0;
    zcode[idx] = code;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    lk_req = 1'b0;
  endtask

  task automatic check_direct(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not finish (act=running exp=done)");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; lk_req = 0; lk_vaddr = 0; lk_pid = 0; lk_kind = 0; lk_priv = 0;
    xl_inst_en = 0; xl_data_en = 0; ew_en = 0; ew_idx = 0; ew_valid = 0; ew_vpn = 0;
    ew_size = 0; ew_pid = 0; ew_ppn = 0; ew_w = 0; ew_x = 0; ew_attr = 0; ew_zone = 0;
    zw_en = 0; zw_idx = 0; zw_code = 0;
    for (int i = 0; i < 64; i++) mv[i] = 0;
    for (int i = 0; i < 16; i++) zcode[i] = 2'b01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check_direct(lk_hit === 1'b0 && lk_fault === 1'b0, "R1 idle outputs after reset",
                 int'(lk_hit) + int'(lk_fault), 0);

    // R2: pass-through with enables off, then per-kind enable
    look(32'h1234_5678, 8'h01, 2'b00, 0, "R2 read bypass");
    look(32'h0040_0ABC, 8'h01, 2'b10, 0, "R2 fetch bypass");
    @(posedge clk); #1 lk_req = 0; xl_inst_en = 1;
    look(32'h0040_0ABC, 8'h01, 2'b10, 0, "R1 R2 fetch translated, empty array");
    look(32'h0040_0ABC, 8'h01, 2'b01, 0, "R2 store still bypassed");
    @(posedge clk); #1 lk_req = 0; xl_data_en = 1;
    look(32'hABCD_0000, 8'h01, 2'b11, 0, "R1 R2 kind 11 read misses on empty array");

    // R3 R4: 1KB page
    put_ent(5, 1, 32'h1000_0400, 3'd0, 8'h00, 22'h00123, 1, 1, 2'b01, 4'd0);
    look(32'h1000_0400, 8'h07, 2'b00, 0, "R3 R11 1KB first byte");
    look(32'h1000_07FC, 8'h07, 2'b00, 0, "R4 1KB last word");
    look(32'h1000_0800, 8'h07, 2'b00, 0, "R3 1KB one past end misses");
    look(32'h1000_03FF, 8'h07, 2'b00, 0, "R3 1KB one before start misses");

    // 64KB page, store denied, fetch allowed
    put_ent(10, 1, 32'h2003_0000, 3'd3, 8'h00, 22'h3FFC0, 0, 1, 2'b10, 4'd1);
    look(32'h2003_FFF0, 8'h00, 2'b00, 0, "R3 R4 64KB last bytes");
    look(32'h2004_0000, 8'h00, 2'b00, 0, "R3 64KB one past end misses");
    look(32'h2003_1234, 8'h00, 2'b01, 0, "R7 store without W faults");
    look(32'h2003_1234, 8'h00, 2'b10, 0, "R7 fetch with X hits");

    // 16MB page with process ID
    put_ent(20, 1, 32'h8100_0000, 3'd7, 8'h33, 22'h3FF00, 1, 0, 2'b11, 4'd2);
    look(32'h81AB_CDEF, 8'h33, 2'b00, 0, "R3 R4 R5 16MB own pid");
    look(32'h81AB_CDEF, 8'h34, 2'b00, 0, "R5 other pid misses");
    look(32'h81FF_FFFF, 8'h33, 2'b10, 0, "R7 fetch without X faults");
    look(32'h8200_0000, 8'h33, 2'b00, 0, "R3 16MB one past end misses");

    // 1MB page at the top entry index
    put_ent(63, 1, 32'hC030_0000, 3'd5, 8'h00, 22'h15555, 1, 1, 2'b01, 4'd0);
    look(32'hC03F_FFFF, 8'h99, 2'b01, 0, "R3 R4 R5 1MB in entry 63");

    // R6: overlap, lowest index wins
    put_ent(40, 1, 32'h5000_0000, 3'd1, 8'h00, 22'h0AAA0, 1, 1, 2'b10, 4'd0);
    put_ent(2,  1, 32'h5000_0000, 3'd2, 8'h00, 22'h0BBB0, 1, 1, 2'b01, 4'd0);
    look(32'h5000_0100, 8'h01, 2'b00, 0, "R6 overlapping entries, lower wins");
    look(32'h5000_3000, 8'h01, 2'b00, 0, "R6 only the 16KB entry covers");
    put_ent(2, 0, 32'h5000_0000, 3'd2, 8'h00, 22'h0BBB0, 1, 1, 2'b01, 4'd0);
    look(32'h5000_0100, 8'h01, 2'b00, 0, "R6 R10 cleared entry, higher takes over");

    // R8 R9: zone overrides
    put_zone(3, 2'b00);
    put_ent(41, 1, 32'h6000_0000, 3'd0, 8'h00, 22'h00777, 1, 1, 2'b01, 4'd3);
    look(32'h6000_0010, 8'h01, 2'b00, 0, "R8 R9 zone 00 unprivileged faults");
    look(32'h6000_0010, 8'h01, 2'b00, 1, "R8 zone 00 privileged hits");
    put_ent(41, 1, 32'h6000_0000, 3'd0, 8'h00, 22'h00777, 0, 0, 2'b01, 4'd3);
    look(32'h6000_0010, 8'h01, 2'b01, 1, "R8 zone 00 privileged store without W faults");
    put_zone(3, 2'b10);
    look(32'h6000_0010, 8'h01, 2'b01, 0, "R8 R9 zone 10 store allowed");
    look(32'h6000_0010, 8'h01, 2'b10, 0, "R8 zone 10 fetch without X faults");
    put_zone(3, 2'b11);
    look(32'h6000_0010, 8'h01, 2'b10, 0, "R8 zone 11 fetch allowed");
    put_zone(3, 2'b01);
    look(32'h6000_0010, 8'h01, 2'b01, 0, "R7 R9 zone 01 entry permissions");

    // R10: write and lookup in the same cycle
    @(posedge clk); #1;
    drive_ent(41, 0, 22'(32'h6000_0000 >> 10), 3'd0, 8'h00, 22'h00777, 0, 0, 2'b01, 4'd3);
    drive_look(32'h6000_0010, 8'h01, 2'b00, 0);
    q.push_back(predict(32'h6000_0010, 8'h01, 2'b00, 0, "R10 same-cycle lookup sees old entry"));
    model_ent(41, 0, 22'(32'h6000_0000 >> 10), 3'd0, 8'h00, 22'h00777, 0, 0, 2'b01, 4'd3);
    look(32'h6000_0010, 8'h01, 2'b00, 0, "R10 next-cycle lookup sees clear");

    // R11: no request, matching address
    @(posedge clk); #1;
    lk_req = 0; lk_vaddr = 32'h1000_0400; lk_kind = 2'b00;
    @(negedge clk);
    check_direct(lk_hit === 1'b0 && lk_fault === 1'b0, "R11 no request stays quiet",
                 int'(lk_hit) + int'(lk_fault), 0);
    @(negedge clk);
    check_direct(q.size() == 0, "scoreboard drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule